// File: doc/BRIEF.md
# Serial Transmitter with Fractional Bit Timing

This block serializes one byte at a time onto an asynchronous serial line. The caller offers a byte on a valid/ready handshake. Once the byte is taken, the block drives a start bit, 5 to 8 data bits starting with the least significant, an optional parity bit and one or two stop bits. It then returns to the idle level and can take the next byte. The frame shape comes from a packed line-control word. The length of every bit comes from an integer divisor plus a 3-bit fine-adjust field, counted in input-clock cycles.

A divisor of zero means the bit timing has not been set up. In that state the block refuses bytes and keeps the line at its idle level. The line-control word and both timing inputs are captured when a byte is accepted. Changes made to them while a frame is on the wire only apply to the next frame. Two status flags report whether the transmitter is empty and whether the holding buffer is empty. A one-cycle event strobe marks each accepted byte.

Top module: `uart_frac_tx`

## Requirements
- R1: The data length is 5 plus line-control bits [1:0], giving 5 to 8 bits. Data bits leave least significant bit first.
- R2: Line-control bit 2 set gives two stop bits (line high). Clear gives one stop bit.
- R3: Line-control bit 5 enables a parity bit that follows the data. Bits [5:3] = 3'b100 select odd parity, and every other code with bit 5 set selects even parity. Parity is computed over the active data bits only. Line-control bit 6 has no effect on the frame.
- R4: The line idles high. A frame is one low start bit, then the data bits, then the parity bit when enabled, then the stop bits.
- R5: Every bit lasts 16*div + frac + 16 input-clock cycles. Here div is the divisor input and frac is the 3-bit fine-adjust input. The whole frame lasts N times that, where N is the frame's bit count.
- R6: While the divisor input is zero and no frame is in progress, tx_ready_o stays low and the line stays high, whatever tx_valid_i does.
- R7: stat_o[2] is transmitter-empty, stat_o[1] is buffer-empty, and stat_o[0] reads 0. Bits 2 and 1 are 1 after reset and when idle. Both are 0 from the cycle after acceptance until the last stop bit ends.
- R8: tx_event_o is high exactly in the cycles in which a byte is accepted (tx_valid_i and tx_ready_o both high).
- R9: No byte is accepted while a frame is in progress. tx_ready_o returns high in the cycle that follows the end of the last stop bit.
- R10: Changes to the line-control, divisor or fine-adjust inputs during a frame do not alter that frame. They apply from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the bit-timing reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_i | input | 7 | Line control: [1:0] length, [2] stop count, [5:3] parity mode, [6] ignored |
| div_i | input | DIV_W | Integer bit-period divisor; zero disables transmission |
| frac_i | input | 3 | Fine adjustment added to the bit period |
| tx_valid_i | input | 1 | A byte is offered |
| tx_data_i | input | DATA_W | Byte to send |
| tx_ready_o | output | 1 | Block can take a byte this cycle |
| tx_event_o | output | 1 | Strobe in each acceptance cycle |
| tx_line_o | output | 1 | Serial output, idle high |
| stat_o | output | 3 | [2] transmitter empty, [1] buffer empty, [0] zero |

## Verification
The bench builds the block with its defaults: a 16-bit divisor, 8-bit data and an unregistered line output. It then drives small divisors (1 and 2) with fine-adjust values of 0, 5 and 7. This gives bit periods of 32 to 55 cycles, so every frame length from the shortest 5-bit frame to the longest 8-bit frame with parity and two stop bits fits in a short run. The same small divisors make the exact ready-low duration countable, which confirms the period formula to the cycle. Switching the divisor to zero between frames exercises the disabled state, and changing the inputs mid-frame exercises the capture at the frame boundary.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   // line-control field layout (positions are decoded by the framer)
   localparam int LCR_W      = 7;
   localparam int LEN_LSB    = 0;
   localparam int LEN_FLD_W  = 2;
   localparam int STOP_BIT   = 2;
   localparam int PAR_EN_BIT = 5;
   localparam int MIN_LEN    = 5;
   localparam int FRAC_W     = 3;
   localparam logic [2:0] PAR_ODD_CODE = 3'b100;

   // start + data + parity + two stops
   function automatic int frame_width(input int data_w);
      return 1 + data_w + 1 + 2;
   endfunction
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = frame_width(DATA_W),
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data_i,
   input  logic [LCR_W-1:0]   lcr_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [CNT_W-1:0]   nbits_o
);
   localparam int IDX_W = $clog2(FRAME_W);

   logic [DATA_W-1:0] dmask;
   logic              odd_sel;
   logic              par_bit;
   logic [IDX_W-1:0]  par_idx;

   // active-data mask: low MIN_LEN bits always active, the rest by length field
   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      if (g < MIN_LEN) begin : g_fixed
         assign dmask[g] = 1'b1;
      end else begin : g_sel
         assign dmask[g] = (int'(lcr_i[LEN_LSB +: LEN_FLD_W]) >= g - MIN_LEN + 1);
      end
   end

   assign odd_sel = (lcr_i[PAR_EN_BIT -: 3] == PAR_ODD_CODE);
   assign par_bit = (^(data_i & dmask)) ^ odd_sel;
   assign par_idx = IDX_W'(1 + MIN_LEN) + IDX_W'(lcr_i[LEN_LSB +: LEN_FLD_W]);

   always_comb begin
      frame_o              = '1;
      frame_o[0]           = 1'b0;
      frame_o[DATA_W:1]    = data_i | ~dmask;
      if (lcr_i[PAR_EN_BIT]) frame_o[par_idx] = par_bit;
      nbits_o = CNT_W'(1 + MIN_LEN) + CNT_W'(lcr_i[LEN_LSB +: LEN_FLD_W])
              + CNT_W'(lcr_i[PAR_EN_BIT]) + (lcr_i[STOP_BIT] ? CNT_W'(2) : CNT_W'(1));
   end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer
   import uart_tx_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int PER_W = DIV_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              busy_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              tick_o
);
   logic [PER_W-1:0] period_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] period_d;

   assign period_d = PER_W'({div_i, 4'b0000}) + PER_W'(frac_i) + PER_W'(16);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= PER_W'(16);
         cnt_q    <= '0;
      end else if (load_i) begin
         period_q <= period_d;
         cnt_q    <= period_d - PER_W'(1);
      end else if (busy_i) begin
         if (cnt_q == '0) cnt_q <= period_q - PER_W'(1);
         else             cnt_q <= cnt_q - PER_W'(1);
      end
   end

   assign tick_o = busy_i && (cnt_q == '0);

   // R5: the down-counter never leaves the captured period window
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (cnt_q < period_q));

   // R10: period stays frozen while a frame runs
   p_period_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !load_i && $past(busy_i)) |-> $stable(period_q));
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
   import uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LCR_W-1:0]     lcr_i,
   input  logic [DIV_W-1:0]     div_i,
   input  logic [FRAC_W-1:0]    frac_i,
   input  logic                 tx_valid_i,
   input  logic [DATA_W-1:0]    tx_data_i,
   output logic                 tx_ready_o,
   output logic                 tx_event_o,
   output logic                 tx_line_o,
   output logic [2:0]           stat_o
);
   localparam int FRAME_W = frame_width(DATA_W);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W != MIN_LEN + 3) begin : g_chk_data
      $error("DATA_W must equal the longest selectable length");
   end
   if (DIV_W < 1) begin : g_chk_div
      $error("DIV_W must be positive");
   end

   logic               busy_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   left_q;
   logic [FRAME_W-1:0] frame_w;
   logic [CNT_W-1:0]   nbits_w;
   logic               accept;
   logic               tick;
   logic               line_raw;

   assign tx_ready_o = !busy_q && (div_i != '0);
   assign accept     = tx_valid_i && tx_ready_o;
   assign tx_event_o = accept;
   assign stat_o     = {!busy_q, !busy_q, 1'b0};

   uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
      .data_i  (tx_data_i),
      .lcr_i   (lcr_i),
      .frame_o (frame_w),
      .nbits_o (nbits_w)
   );

   uart_tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .busy_i (busy_q),
      .div_i  (div_i),
      .frac_i (frac_i),
      .tick_o (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shreg_q <= '1;
         left_q  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         shreg_q <= frame_w;
         left_q  <= nbits_w;
      end else if (tick) begin
         shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
         left_q  <= left_q - CNT_W'(1);
         if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
   end

   assign line_raw = busy_q ? shreg_q[0] : 1'b1;

   if (REG_OUT) begin : g_line_reg
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b1;
         else        line_q <= line_raw;
      end
      assign tx_line_o = line_q;
   end else begin : g_line_comb
      assign tx_line_o = line_raw;
   end

   // R4: the cycle after acceptance carries the low start bit
   p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (line_raw == 1'b0));

   // R7: both empty flags drop once a byte is taken
   p_status_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (stat_o[2:1] == 2'b00));

   // R6: unconfigured timing keeps the line idle and refuses bytes
   p_idle_div0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((div_i == '0) && !busy_q) |-> (!tx_ready_o && line_raw));

   // R9: no second acceptance right after one
   p_no_back2back_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tx_ready_o);
endmodule

// File: tb/uart_frac_tx_bench.sv
`timescale 1ns/1ps
module uart_frac_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] lcr = 7'h03;
   logic [15:0] div = 16'd0;
   logic [2:0] frac = 3'd0;
   logic       valid = 1'b0;
   logic [7:0] data = 8'h00;
   logic       ready, event_s, line;
   logic [2:0] stat;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic [11:0] q_frame[$];
   int          q_len[$];
   int          q_per[$];

   always #2 clk = ~clk;

   uart_frac_tx u_uart_frac_tx (
      .clk(clk), .rst_n(rst_n), .lcr_i(lcr), .div_i(div), .frac_i(frac),
      .tx_valid_i(valid), .tx_data_i(data), .tx_ready_o(ready),
      .tx_event_o(event_s), .tx_line_o(line), .stat_o(stat)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // expected frame built from R1..R4
   task automatic build(input logic [7:0] d, input logic [6:0] l,
                        output logic [11:0] f, output int n);
      int  nd;
      logic p;
      nd = 5 + int'(l[1:0]);
      f = '1;
      f[0] = 1'b0;
      p = 1'b0;
      for (int i = 0; i < nd; i++) begin
         f[1+i] = d[i];
         p = p ^ d[i];
      end
      n = 1 + nd;
      if (l[5]) begin
         if (l[5:3] == 3'b100) p = ~p;
         f[n] = p;
         n++;
      end
      n = n + (l[2] ? 2 : 1);
   endtask

   task automatic send(input logic [7:0] d, input logic [6:0] l,
                       input logic [15:0] dv, input logic [2:0] fr, input bit chg);
      logic [11:0] f;
      int n, per, cnt;
      @(negedge clk);
      lcr = l; div = dv; frac = fr; data = d; valid = 1'b1;
      #1;
      while (!ready) begin @(negedge clk); #1; end
      check(event_s == 1'b1, "R8 strobe at accept", event_s, 1);
      build(d, l, f, n);
      per = 16 * int'(dv) + int'(fr) + 16;
      q_frame.push_back(f); q_len.push_back(n); q_per.push_back(per);
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      check(stat == 3'b000, "R7 flags clear while busy", stat, 0);
      check(event_s == 1'b0, "R8 strobe one cycle", event_s, 0);
      if (chg) begin
         lcr = l ^ 7'h27; div = dv + 16'd3; frac = ~fr; data = ~d;
         valid = 1'b1;
      end
      cnt = 1;
      while (!ready) begin @(negedge clk); cnt++; end
      valid = 1'b0;
      check(cnt == n * per + 1, "R5/R9 frame duration", cnt, n * per + 1);
      check(stat == 3'b110, "R7 flags set when idle", stat, 3'b110);
   endtask

   // monitor: pops the expected frame and samples each bit near its middle
   initial begin
      logic prev;
      logic [11:0] cap, f;
      int n, per;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && prev && !line) begin
            if (q_frame.size() == 0) begin
               check(1'b0, "R6 unexpected start bit", 0, 1);
            end else begin
               f = q_frame.pop_front(); n = q_len.pop_front(); per = q_per.pop_front();
               cap = '1;
               repeat (per / 2 - 1) @(negedge clk);
               cap[0] = line;
               for (int i = 1; i < n; i++) begin
                  repeat (per) @(negedge clk);
                  cap[i] = line;
               end
               for (int i = n; i < 12; i++) cap[i] = 1'b1;
               check(cap == f, "R1/R2/R3/R4/R10 frame bits", cap, f);
               repeat (per - per / 2 + 1) @(negedge clk);
            end
         end
         prev = line;
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(line == 1'b1, "R4 idle high after reset", line, 1);
      check(stat == 3'b110, "R7 reset flags", stat, 3'b110);
      check(ready == 1'b0, "R6 ready low with zero divisor", ready, 0);

      // R6: offering bytes with zero divisor does nothing
      valid = 1'b1; data = 8'h00;
      ok = 1'b1;
      repeat (40) begin
         @(negedge clk);
         if (ready || !line || event_s) ok = 1'b0;
      end
      valid = 1'b0;
      check(ok, "R6 zero divisor holds idle", ok, 1);

      send(8'hA5, 7'h03, 16'd1, 3'd0, 1'b0);   // R1 8 data, no parity, 1 stop
      send(8'h3C, 7'h24, 16'd1, 3'd5, 1'b0);   // R3 odd parity, R2 two stops, 5 data
      send(8'h5A, 7'h29, 16'd2, 3'd7, 1'b1);   // R3 even parity, 6 data, R10 mid-frame change
      send(8'h4B, 7'h7A, 16'd1, 3'd3, 1'b1);   // R3 mode 111 even, bit6 ignored, R10
      send(8'h4B, 7'h3A, 16'd1, 3'd3, 1'b0);   // same without bit6
      send(8'hFF, 7'h27, 16'd1, 3'd1, 1'b0);   // R3 odd over all ones, 2 stops
      send(8'h81, 7'h1B, 16'd1, 3'd2, 1'b0);   // R3 bit5 clear: no parity bit

      // R6 again after use
      div = 16'd0; valid = 1'b1;
      ok = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (ready || !line) ok = 1'b0;
      end
      valid = 1'b0;
      check(ok, "R6 divisor cleared later", ok, 1);

      repeat (20) @(negedge clk);
      check(q_frame.size() == 0, "R4 every frame observed", q_frame.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule